// File: doc/BRIEF.md
# Code Phase Counter with Slew

This block follows the code phase of one spreading-code channel in units of half chips. A code oscillator supplies a one-cycle half-chip enable. The block passes that enable on to the code generator and counts each enable it passes. The code generator raises an epoch pulse at the end of every code period. That pulse clears the counter and advances an epoch count. A measurement strobe captures the counter into a read register that is 16 bits wide.

Software shifts the code by writing a slew count. The block then withholds that many half-chip enables from the generator. The mode input sets when a slew begins. In update mode the slew begins at the next epoch pulse. In preset mode it begins at the next measurement strobe, which also resets the code generator and the counter. Each slew write arms exactly one slew. A test port can load the counter, but only while the test enable is high.

Top module: `code_phase_track`

## Requirements
- R1: After reset, `phase_now`, `epoch`, `phase_rd` and the slew state are all zero, and `slewing` is low.
- R2: Outside a slew, `gen_en` follows `half_en` in the same cycle. Each such enable adds 1 to `phase_now` at the next edge.
- R3: A `dump` pulse sets `phase_now` to 0 at the next edge and adds 1 to `epoch`, which wraps at its width. `dump` takes priority over counting and over a test write in the same cycle.
- R4: A `tic` pulse with `slewing` low stores `phase_now` in `phase_rd[10:0]` at the next edge. Bits 15 to 11 always read 0, and the value holds until the next `tic`. A count of 2046 captured before `dump` arrives reads back as 2046.
- R5: A `tic` while `slewing` is high stores 0 in `phase_rd`.
- R6: In update mode (`preset_mode` = 0), an armed slew starts on `dump`. The following N `half_en` pulses are withheld: `gen_en` stays low and `phase_now` holds. `slewing` stays high until the last withheld pulse has been taken.
- R7: In preset mode (`preset_mode` = 1), an armed slew starts on `tic` and not on `dump`. In that cycle `gen_rst` pulses, and `phase_now` becomes 0 at the next edge. `gen_rst` never rises in update mode or without a `tic`.
- R8: A `slew_wr` latches `slew_val` and arms one slew. The start event consumes the armed slew, so a later start event with no new write withholds nothing. A slew value of 0 withholds nothing.
- R9: The full slew value is always withheld with no folding. A value of 2047 withholds 2047 enables, which moves the code by 1 half chip mod 2046, one code period late.
- R10: `test_wr` loads `test_val` into `phase_now` only while `test_en` = 1. At any other time the write is ignored and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preset_mode | input | 1 | 0 = update mode, 1 = preset mode |
| half_en | input | 1 | Half-chip enable from the code oscillator |
| dump | input | 1 | End-of-code-period pulse from the code generator |
| tic | input | 1 | Measurement strobe |
| slew_wr | input | 1 | Slew register write strobe |
| slew_val | input | 11 | Slew amount in half chips |
| test_en | input | 1 | Test-mode enable for counter writes |
| test_wr | input | 1 | Counter write strobe |
| test_val | input | 11 | Value loaded by a counter write |
| gen_en | output | 1 | Half-chip enable passed on to the code generator |
| gen_rst | output | 1 | Code generator reset, preset-mode slew start |
| slewing | output | 1 | A slew is in progress |
| phase_now | output | 11 | Live half-chip counter |
| phase_rd | output | 16 | Code phase captured on `tic` |
| epoch | output | 8 | Epoch count |

## Verification
The hardest cases to reach are a `tic` that lands inside a slew's hold window and a capture of count 2046. To reach the first, the bench arms a slew, starts it with `dump`, and strobes `tic` while enables are still being withheld. To reach the second, it preloads the counter through the test port and steps up to 2046 before sending `tic`. A 2047 slew is driven with an enable on every cycle, so the whole hold window can be compared with the reference model.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic {
    MODE_UPDATE = 1'b0,
    MODE_PRESET = 1'b1
  } cpc_mode_e;
endpackage

// File: rtl/cpc_slew_ctrl.sv
module cpc_slew_ctrl
  import cpc_pkg::*;
#(
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset_mode,
  input  logic          half_en,
  input  logic          dump,
  input  logic          tic,
  input  logic          slew_wr,
  input  logic [SW-1:0] slew_val,
  output logic          slewing,
  output logic          gen_en,
  output logic          gen_rst
);
  logic [SW-1:0] slew_q;
  logic [SW-1:0] remain_q;
  logic          armed_q;
  logic          start;
  cpc_mode_e     mode;

  assign mode    = cpc_mode_e'(preset_mode);
  assign slewing = (remain_q != '0);
  assign gen_en  = half_en && !slewing;

  always_comb begin
    unique case (mode)
      MODE_PRESET: start = armed_q && tic;
      default:     start = armed_q && dump;
    endcase
  end

  assign gen_rst = start && (mode == MODE_PRESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slew_q   <= '0;
      remain_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (slew_wr) begin
        slew_q  <= slew_val;
        armed_q <= 1'b1;
      end else if (start) begin
        armed_q <= 1'b0;
      end
      if (start)
        remain_q <= slew_q;
      else if (slewing && half_en)
        remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/cpc_phase_cnt.sv
module cpc_phase_cnt #(
  parameter int PH_W = 11,
  parameter int EP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dump,
  input  logic            clr,
  input  logic            gen_en,
  input  logic            test_en,
  input  logic            test_wr,
  input  logic [PH_W-1:0] test_val,
  output logic [PH_W-1:0] cnt,
  output logic [EP_W-1:0] epoch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      epoch <= '0;
    end else begin
      if (dump || clr)
        cnt <= '0;
      else if (test_en && test_wr)
        cnt <= test_val;
      else if (gen_en)
        cnt <= cnt + 1'b1;
      if (dump)
        epoch <= epoch + 1'b1;
    end
  end
endmodule

// File: rtl/cpc_capture.sv
module cpc_capture #(
  parameter int PH_W = 11,
  parameter int RD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tic,
  input  logic            slewing,
  input  logic [PH_W-1:0] cnt,
  output logic [RD_W-1:0] phase_rd
);
  logic [PH_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cap_q <= '0;
    else if (tic)
      cap_q <= slewing ? '0 : cnt;
  end

  generate
    if (RD_W > PH_W) begin : g_pad
      assign phase_rd = {{(RD_W-PH_W){1'b0}}, cap_q};
    end else begin : g_nopad
      assign phase_rd = cap_q[RD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/code_phase_track.sv
module code_phase_track #(
  parameter int PH_W = 11,
  parameter int RD_W = 16,
  parameter int EP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            preset_mode,
  input  logic            half_en,
  input  logic            dump,
  input  logic            tic,
  input  logic            slew_wr,
  input  logic [PH_W-1:0] slew_val,
  input  logic            test_en,
  input  logic            test_wr,
  input  logic [PH_W-1:0] test_val,
  output logic            gen_en,
  output logic            gen_rst,
  output logic            slewing,
  output logic [PH_W-1:0] phase_now,
  output logic [RD_W-1:0] phase_rd,
  output logic [EP_W-1:0] epoch
);
  cpc_slew_ctrl #(.SW(PH_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .preset_mode(preset_mode), .half_en(half_en),
    .dump(dump), .tic(tic), .slew_wr(slew_wr), .slew_val(slew_val),
    .slewing(slewing), .gen_en(gen_en), .gen_rst(gen_rst)
  );

  cpc_phase_cnt #(.PH_W(PH_W), .EP_W(EP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dump(dump), .clr(gen_rst), .gen_en(gen_en),
    .test_en(test_en), .test_wr(test_wr), .test_val(test_val),
    .cnt(phase_now), .epoch(epoch)
  );

  cpc_capture #(.PH_W(PH_W), .RD_W(RD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tic(tic), .slewing(slewing),
    .cnt(phase_now), .phase_rd(phase_rd)
  );
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int PH_W = 11,
  parameter int RD_W = 16,
  parameter int EP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            preset_mode,
  input logic            dump,
  input logic            tic,
  input logic            test_en,
  input logic            test_wr,
  input logic            gen_en,
  input logic            gen_rst,
  input logic            slewing,
  input logic [PH_W-1:0] phase_now,
  input logic [RD_W-1:0] phase_rd,
  input logic [EP_W-1:0] epoch
);
  AST_SLEW_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    slewing |-> !gen_en); // R6
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rd[RD_W-1:PH_W] == '0); // R4
  AST_DUMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> phase_now == '0); // R3
  AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> epoch == EP_W'($past(epoch) + 1'b1)); // R3
  AST_TIC_IN_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
    (tic && slewing) |=> phase_rd == '0); // R5
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dump && !gen_rst && !gen_en && !(test_en && test_wr)) |=> $stable(phase_now)); // R10
  AST_GENRST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rst |-> (preset_mode && tic)); // R7
endmodule

bind code_phase_track cpc_checker #(.PH_W(PH_W), .RD_W(RD_W), .EP_W(EP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .preset_mode(preset_mode), .dump(dump), .tic(tic),
  .test_en(test_en), .test_wr(test_wr), .gen_en(gen_en), .gen_rst(gen_rst),
  .slewing(slewing), .phase_now(phase_now), .phase_rd(phase_rd), .epoch(epoch)
);

// File: tb/sim_code_phase_track.sv
module sim_code_phase_track;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic preset_mode = 1'b0, half_en = 1'b0, dump = 1'b0, tic = 1'b0;
  logic slew_wr = 1'b0, test_en = 1'b0, test_wr = 1'b0;
  logic [10:0] slew_val = '0, test_val = '0;
  logic gen_en, gen_rst, slewing;
  logic [10:0] phase_now;
  logic [15:0] phase_rd;
  logic [7:0] epoch;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_cnt = 0, m_epoch = 0, m_cap = 0, m_rem = 0, m_sreg = 0;
  bit m_armed = 1'b0;

  always #10 clk = ~clk;

  code_phase_track u0 (
    .clk(clk), .rst_n(rst_n), .preset_mode(preset_mode), .half_en(half_en),
    .dump(dump), .tic(tic), .slew_wr(slew_wr), .slew_val(slew_val),
    .test_en(test_en), .test_wr(test_wr), .test_val(test_val),
    .gen_en(gen_en), .gen_rst(gen_rst), .slewing(slewing),
    .phase_now(phase_now), .phase_rd(phase_rd), .epoch(epoch)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "phase_now", int'(phase_now), m_cnt);
    chk(req, "epoch", int'(epoch), m_epoch);
    chk(req, "phase_rd", int'(phase_rd), m_cap);
    chk(req, "slewing", int'(slewing), int'(m_rem != 0));
  endtask

  // One clock: apply inputs, check combinational outputs, advance model.
  task automatic step(string req, bit he, bit dp, bit tc, bit sw = 0, int sv = 0,
                      bit te = 0, bit tw = 0, int tv = 0);
    bit sl, ge, st, gr;
    @(negedge clk);
    check_state(req);
    half_en = he; dump = dp; tic = tc; slew_wr = sw; slew_val = 11'(sv);
    test_en = te; test_wr = tw; test_val = 11'(tv);
    #1;
    sl = (m_rem != 0);
    ge = he && !sl;
    st = m_armed && (preset_mode ? tc : dp);
    gr = st && preset_mode;
    chk(req, "gen_en", int'(gen_en), int'(ge));
    chk(req, "gen_rst", int'(gen_rst), int'(gr));
    @(posedge clk);
    if (tc) m_cap = sl ? 0 : m_cnt;
    if (dp || gr) m_cnt = 0;
    else if (te && tw) m_cnt = tv;
    else if (ge) m_cnt = (m_cnt + 1) % 2048;
    if (dp) m_epoch = (m_epoch + 1) % 256;
    if (st) m_rem = m_sreg;
    else if (sl && he) m_rem = m_rem - 1;
    if (sw) begin m_armed = 1'b1; m_sreg = sv; end
    else if (st) m_armed = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    // R2: counting with gaps
    for (int i = 0; i < 12; i++) step("R2", (i % 3) != 1, 0, 0);
    // R3: dump with simultaneous enable and test write
    step("R3", 1, 1, 0, 0, 0, 1, 1, 77);
    for (int i = 0; i < 5; i++) step("R3", 1, 0, 0);
    // R4: capture and hold
    step("R4", 1, 0, 1);
    for (int i = 0; i < 4; i++) step("R4", 1, 0, 0);
    // R6: update-mode slew of 3 started by dump, with a tic mid-slew (R5)
    step("R6", 0, 0, 0, 1, 3);
    for (int i = 0; i < 4; i++) step("R6", 1, 0, 0);
    step("R6", 1, 1, 0);
    step("R6", 1, 0, 0);
    step("R5", 0, 0, 1);
    for (int i = 0; i < 5; i++) step("R6", 1, 0, 0);
    step("R5", 0, 0, 1);
    // R8: a second dump with no new write withholds nothing; zero slew too
    step("R8", 1, 1, 0);
    for (int i = 0; i < 3; i++) step("R8", 1, 0, 0);
    step("R8", 0, 0, 0, 1, 0);
    step("R8", 1, 1, 0);
    for (int i = 0; i < 3; i++) step("R8", 1, 0, 0);
    // R10: test write ignored without test_en, loads with it
    step("R10", 0, 0, 0, 0, 0, 0, 1, 500);
    step("R10", 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 1, 2040);
    // R4: reach 2046 and capture before dump
    for (int i = 0; i < 6; i++) step("R4", 1, 0, 0);
    step("R4", 0, 0, 1);
    step("R4", 0, 1, 0);
    step("R4", 0, 0, 0);
    // R7: preset mode, dump does not start, tic does
    preset_mode = 1'b1;
    step("R7", 1, 0, 0, 1, 4);
    step("R7", 1, 1, 0);
    for (int i = 0; i < 3; i++) step("R7", 1, 0, 0);
    step("R7", 1, 0, 1);
    step("R7", 1, 0, 0);
    step("R5", 1, 0, 1);
    for (int i = 0; i < 6; i++) step("R7", 1, 0, 0);
    step("R7", 1, 0, 1);
    step("R7", 1, 0, 0);
    // R9: full 2047 slew in update mode
    preset_mode = 1'b0;
    step("R9", 0, 0, 0, 1, 2047);
    step("R9", 1, 1, 0);
    for (int i = 0; i < 2050; i++) step("R9", 1, 0, 0);
    step("R9", 0, 0, 1);
    step("R9", 0, 0, 0);
    @(negedge clk);
    check_state("R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule